// File: doc/BRIEF.md
# Serial LED Shift Chain Controller

This block drives an external LED board built from a serial-in shift register followed by a parallel output latch. Three wires go to the board: a serial clock, a serial data line and a latch strobe. The serial clock is divided down from the system clock. Each of its half-periods is a programmable number of 64-cycle units. Serial data changes when the serial clock falls, so the board shifts each bit in on the rising edge.

The block runs continuously while it is enabled. Each frame is made of up to four segments, sent in a fixed order: a header of 0 to 32 user bits, one status field for each enabled port (lowest port first), an optional 17-bit debug word, and a trailer of 0 to 32 user bits. Empty segments take no time at all. After the last bit, the latch strobe is held high for one serial clock period, and the next frame follows at once.

The header and trailer words are held in registers with write, bitwise-set and bitwise-clear access. An inversion control suits boards whose LEDs are active low. Per-port status bits and the debug word come from elsewhere and are read as inputs.

Top module: `led_chain_ctrl`

## Requirements
- R1: While `chain_en` is high, each half-period of `sclk` lasts max(`phase_len`,1)×64 system clocks. A `phase_len` of 0 acts as 1. After `chain_en` rises, `sclk` stays low for one half-period and then rises.
- R2: `sdat` changes only in the cycle where `sclk` falls (or when the chain starts or stops). It is stable for the whole high half of `sclk`, which is where the board samples it.
- R3: A frame sends its bits in this order: header bits `hdr_len` starting at bit 0 of the header word; then, for each port p with `port_mask[p]`=1 in ascending p, bits `port_status[p*6 +: 6]` LSB first; then `dbg_word` LSB first if `dbg_en`=1; then trailer bits starting at bit 0. Each bit occupies one `sclk` period.
- R4: A header or trailer length above 32 is treated as 32. A zero length, an all-zero mask or `dbg_en`=0 adds no `sclk` periods to the frame.
- R5: After the last data bit, `slatch` is high for exactly one `sclk` period, with `sdat` at its inactive level. The next frame's first bit follows immediately after.
- R6: With `dat_invert`=1 every bit on `sdat` is the complement of the data bit, and the inactive level is 1. With `dat_invert`=0 data is sent as is.
- R7: While `chain_en` is low, `sclk` and `slatch` are 0 and `sdat` is at its inactive level. Raising `chain_en` starts a new frame at its first bit.
- R8: The header word (`ud_sel`=0) and the trailer word (`ud_sel`=1) reset to 0. When `ud_wr`=1, `ud_op` 0 loads `ud_wdata`, 1 ORs it in, 2 clears the bits that are 1 in it, and 3 leaves the word unchanged.
- R9: Segment lengths, `port_mask` and `dbg_en` are sampled when a frame starts. A change in the middle of a frame takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_en | input | 1 | Runs the shift chain while high |
| dat_invert | input | 1 | Inverts serial data for active-low LEDs |
| phase_len | input | 7 | Half-period of the serial clock in 64-clock units |
| hdr_len | input | 6 | Header bit count (clamped to 32) |
| trl_len | input | 6 | Trailer bit count (clamped to 32) |
| port_mask | input | 8 | Ports whose status fields are sent |
| port_status | input | 48 | Six status bits per port, port p at [p*6 +: 6] |
| dbg_en | input | 1 | Appends the debug word |
| dbg_word | input | 17 | Debug data |
| ud_wr | input | 1 | User data write strobe |
| ud_sel | input | 1 | 0 selects the header word, 1 the trailer word |
| ud_op | input | 2 | 0 load, 1 set bits, 2 clear bits, 3 no change |
| ud_wdata | input | 32 | User data write value |
| sclk | output | 1 | Serial clock to the board |
| sdat | output | 1 | Serial data to the board |
| slatch | output | 1 | Latch strobe to the board |

## Verification
The first rising edge of `sclk` is due exactly one half-period after the edge at which `chain_en` is seen high, and each later rise is due one full period after the one before. The monitor counts system clocks between these events and compares them with the period it derives from `phase_len`. Each expected bit is due at a rising edge of `sclk`, so the monitor pops the scoreboard only at those edges. It samples one time unit after the system clock edge, which makes sure the value seen is the one the board would capture. Register writes are due one clock after their strobe, and they are checked through the header and trailer bits of the frame that follows. Configuration changes made in the middle of a frame are expected in the next frame's items, not the current one's.

// File: rtl/led_chain_pkg.sv
// Shared types for the serial LED shift chain controller.
// Assumes: segment codes are ordered by their position in a frame, so a
// numeric comparison of two codes tells which segment comes first.
package led_chain_pkg;

    typedef enum logic [2:0] {
        SEG_HDR   = 3'd0,
        SEG_PORT  = 3'd1,
        SEG_DBG   = 3'd2,
        SEG_TRL   = 3'd3,
        SEG_LATCH = 3'd4
    } seg_e;

    typedef enum logic [1:0] {
        UD_LOAD  = 2'd0,
        UD_SET   = 2'd1,
        UD_CLEAR = 2'd2,
        UD_KEEP  = 2'd3
    } ud_op_e;

endpackage

// File: rtl/led_ud_word.sv
// One user-data word with load, bitwise-set and bitwise-clear access.
// Assumes: the write strobe is already decoded for this word.
module led_ud_word
    import led_chain_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  ud_op_e       op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] word_q
);

    // Apply the requested write operation to the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en) begin
            case (op)
                UD_LOAD:  word_q <= wdata;
                UD_SET:   word_q <= word_q | wdata;
                UD_CLEAR: word_q <= word_q & ~wdata;
                default:  word_q <= word_q;
            endcase
        end
    end

endmodule

// File: rtl/led_sclk_gen.sv
// Serial clock generator. Each half-period lasts max(phase,1)*UNIT system
// clocks. The serial clock starts low on a chain start, and a one-cycle
// slot_adv pulse marks each falling edge, where the next bit begins.
// Assumes: UNIT is a power of two. 'start' is high for one cycle when the
// chain is first seen enabled.
module led_sclk_gen #(
    parameter int PHASE_W = 7,
    parameter int UNIT    = 64,
    localparam int UNIT_SH = $clog2(UNIT),
    localparam int HC_W    = PHASE_W + UNIT_SH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               start,
    input  logic [PHASE_W-1:0] phase,
    output logic               sclk_q,
    output logic               slot_adv,
    output logic [HC_W-1:0]    half_cnt
);

    logic [PHASE_W-1:0] ph_eff;
    logic [HC_W-1:0]    half_lim;
    logic               half_end;

    // Work out the half-period length; a zero phase acts as one unit.
    always_comb begin
        ph_eff   = (phase == '0) ? PHASE_W'(1) : phase;
        half_lim = {ph_eff, {UNIT_SH{1'b0}}};
        half_end = (half_cnt >= half_lim - 1'b1);
        slot_adv = enable && !start && half_end && sclk_q;
    end

    // Count the half-period and toggle the serial clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || start) begin
            half_cnt <= '0;
            sclk_q   <= 1'b0;
        end else if (half_end) begin
            half_cnt <= '0;
            sclk_q   <= ~sclk_q;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/led_frame_seq.sv
// Frame sequencer. It walks the header, the enabled port fields, the debug
// word, the trailer and the latch slot, and skips every empty segment. It
// registers the serial bit for each slot. Lengths, the mask and the debug
// enable are taken at frame start; data bits are read when their slot begins.
// Assumes: slot_adv pulses at each serial clock falling edge.
module led_frame_seq
    import led_chain_pkg::*;
#(
    parameter int UD_W   = 32,
    parameter int NPORT  = 8,
    parameter int STW    = 6,
    parameter int DBG_W  = 17,
    localparam int CNT_W = $clog2(UD_W + 1),
    localparam int MAXL  = (UD_W > DBG_W) ? ((UD_W > STW) ? UD_W : STW)
                                          : ((DBG_W > STW) ? DBG_W : STW),
    localparam int IDX_W = $clog2(MAXL),
    localparam int PRT_W = $clog2(NPORT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   start,
    input  logic                   slot_adv,
    input  logic [CNT_W-1:0]       hdr_len,
    input  logic [CNT_W-1:0]       trl_len,
    input  logic [NPORT-1:0]       port_mask,
    input  logic                   dbg_en,
    input  logic [UD_W-1:0]        hdr_word,
    input  logic [UD_W-1:0]        trl_word,
    input  logic [NPORT*STW-1:0]   port_status,
    input  logic [DBG_W-1:0]       dbg_word,
    output seg_e                   seg_q,
    output logic                   dat_q,
    output logic                   running_q
);

    typedef struct packed {
        seg_e             seg;
        logic [IDX_W-1:0] idx;
        logic [PRT_W-1:0] prt;
    } pos_t;

    pos_t             pos_q, pos_nxt, pos_first;
    logic [CNT_W-1:0] s_hlen, s_tlen, l_hlen, l_tlen;
    logic [NPORT-1:0] s_mask;
    logic             s_dbg, frame_start;

    // Find the first non-empty slot at or after segment 'from'.
    function automatic pos_t seek(seg_e from, int pfrom, logic [CNT_W-1:0] hl,
                                  logic [CNT_W-1:0] tl, logic [NPORT-1:0] mk,
                                  logic de);
        pos_t r;
        logic hit;
        r.seg = SEG_LATCH;
        r.idx = '0;
        r.prt = '0;
        hit   = 1'b0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (p >= pfrom && mk[p]) begin
                r.prt = PRT_W'(p);
                hit   = 1'b1;
            end
        end
        if (from == SEG_HDR && hl != '0)
            r.seg = SEG_HDR;
        else if (from <= SEG_PORT && hit)
            r.seg = SEG_PORT;
        else if (from <= SEG_DBG && de)
            r.seg = SEG_DBG;
        else if (from <= SEG_TRL && tl != '0)
            r.seg = SEG_TRL;
        if (r.seg != SEG_PORT)
            r.prt = '0;
        return r;
    endfunction

    // Select the serial data bit for a slot; the latch slot sends 0.
    function automatic logic bit_of(pos_t q, logic [UD_W-1:0] hw,
                                    logic [UD_W-1:0] tw,
                                    logic [NPORT*STW-1:0] ps,
                                    logic [DBG_W-1:0] dw);
        case (q.seg)
            SEG_HDR:  return hw[q.idx];
            SEG_PORT: return ps[int'(q.prt) * STW + int'(q.idx)];
            SEG_DBG:  return dw[q.idx];
            SEG_TRL:  return tw[q.idx];
            default:  return 1'b0;
        endcase
    endfunction

    // Clamp the live lengths and find the first slot of a new frame.
    always_comb begin
        l_hlen      = (hdr_len > CNT_W'(UD_W)) ? CNT_W'(UD_W) : hdr_len;
        l_tlen      = (trl_len > CNT_W'(UD_W)) ? CNT_W'(UD_W) : trl_len;
        pos_first   = seek(SEG_HDR, 0, l_hlen, l_tlen, port_mask, dbg_en);
        frame_start = start || (slot_adv && pos_q.seg == SEG_LATCH);
    end

    // Step to the next slot within the frame, using the sampled lengths.
    always_comb begin
        pos_nxt = pos_q;
        case (pos_q.seg)
            SEG_HDR:
                if (int'(pos_q.idx) + 1 < int'(s_hlen))
                    pos_nxt.idx = pos_q.idx + 1'b1;
                else
                    pos_nxt = seek(SEG_PORT, 0, s_hlen, s_tlen, s_mask, s_dbg);
            SEG_PORT:
                if (int'(pos_q.idx) + 1 < STW)
                    pos_nxt.idx = pos_q.idx + 1'b1;
                else
                    pos_nxt = seek(SEG_PORT, int'(pos_q.prt) + 1, s_hlen,
                                   s_tlen, s_mask, s_dbg);
            SEG_DBG:
                if (int'(pos_q.idx) + 1 < DBG_W)
                    pos_nxt.idx = pos_q.idx + 1'b1;
                else
                    pos_nxt = seek(SEG_TRL, 0, s_hlen, s_tlen, s_mask, s_dbg);
            SEG_TRL:
                if (int'(pos_q.idx) + 1 < int'(s_tlen))
                    pos_nxt.idx = pos_q.idx + 1'b1;
                else
                    pos_nxt = seek(SEG_LATCH, 0, s_hlen, s_tlen, s_mask, s_dbg);
            default:
                pos_nxt = pos_q;
        endcase
    end

    // Hold the slot position, the sampled settings and the serial bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            pos_q     <= '0;
            dat_q     <= 1'b0;
            running_q <= 1'b0;
            s_hlen    <= '0;
            s_tlen    <= '0;
            s_mask    <= '0;
            s_dbg     <= 1'b0;
        end else if (frame_start) begin
            pos_q     <= pos_first;
            dat_q     <= bit_of(pos_first, hdr_word, trl_word, port_status, dbg_word);
            running_q <= 1'b1;
            s_hlen    <= l_hlen;
            s_tlen    <= l_tlen;
            s_mask    <= port_mask;
            s_dbg     <= dbg_en;
        end else if (slot_adv) begin
            pos_q <= pos_nxt;
            dat_q <= bit_of(pos_nxt, hdr_word, trl_word, port_status, dbg_word);
        end
    end

    assign seg_q = pos_q.seg;

endmodule

// File: rtl/led_chain_ctrl.sv
// Top of the serial LED shift chain controller. It holds the header and
// trailer words, generates the serial clock, sequences the frame and applies
// the output polarity.
// Assumes: the configuration inputs come from registers in the system clock
// domain. phase_len is not changed while the chain is enabled.
module led_chain_ctrl
    import led_chain_pkg::*;
#(
    parameter int UD_W    = 32,
    parameter int NPORT   = 8,
    parameter int STW     = 6,
    parameter int DBG_W   = 17,
    parameter int PHASE_W = 7,
    parameter int UNIT    = 64,
    localparam int CNT_W  = $clog2(UD_W + 1),
    localparam int HC_W   = PHASE_W + $clog2(UNIT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chain_en,
    input  logic                 dat_invert,
    input  logic [PHASE_W-1:0]   phase_len,
    input  logic [CNT_W-1:0]     hdr_len,
    input  logic [CNT_W-1:0]     trl_len,
    input  logic [NPORT-1:0]     port_mask,
    input  logic [NPORT*STW-1:0] port_status,
    input  logic                 dbg_en,
    input  logic [DBG_W-1:0]     dbg_word,
    input  logic                 ud_wr,
    input  logic                 ud_sel,
    input  logic [1:0]           ud_op,
    input  logic [UD_W-1:0]      ud_wdata,
    output logic                 sclk,
    output logic                 sdat,
    output logic                 slatch
);

    logic [UD_W-1:0] ud_word [2];
    logic            start, slot_adv, running, dat_raw, sclk_q;
    logic [HC_W-1:0] half_cnt;
    seg_e            seg;

    // One register per user-data word: index 0 is the header, 1 the trailer.
    for (genvar g = 0; g < 2; g++) begin : g_ud
        led_ud_word #(.W(UD_W)) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (ud_wr && (ud_sel == 1'(g))),
            .op     (ud_op_e'(ud_op)),
            .wdata  (ud_wdata),
            .word_q (ud_word[g])
        );
    end

    assign start = chain_en && !running;

    led_sclk_gen #(.PHASE_W(PHASE_W), .UNIT(UNIT)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (chain_en),
        .start    (start),
        .phase    (phase_len),
        .sclk_q   (sclk_q),
        .slot_adv (slot_adv),
        .half_cnt (half_cnt)
    );

    led_frame_seq #(.UD_W(UD_W), .NPORT(NPORT), .STW(STW), .DBG_W(DBG_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (chain_en),
        .start       (start),
        .slot_adv    (slot_adv),
        .hdr_len     (hdr_len),
        .trl_len     (trl_len),
        .port_mask   (port_mask),
        .dbg_en      (dbg_en),
        .hdr_word    (ud_word[0]),
        .trl_word    (ud_word[1]),
        .port_status (port_status),
        .dbg_word    (dbg_word),
        .seg_q       (seg),
        .dat_q       (dat_raw),
        .running_q   (running)
    );

    // Drive the board pins; the latch strobe covers the whole latch slot.
    always_comb begin
        sclk   = sclk_q;
        sdat   = dat_raw ^ dat_invert;
        slatch = running && (seg == SEG_LATCH);
    end

endmodule

// File: rtl/led_chain_chk.sv
// Assertion checker for led_chain_ctrl, attached by the bind below.
// Assumes: phase_len is held steady while chain_en is high.
module led_chain_chk
    import led_chain_pkg::*;
#(
    parameter int PHASE_W = 7,
    parameter int UNIT    = 64,
    parameter int HC_W    = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               chain_en,
    input logic [PHASE_W-1:0] phase_len,
    input logic               sclk,
    input logic               slatch,
    input logic               dat_raw,
    input logic               slot_adv,
    input logic [HC_W-1:0]    half_cnt,
    input seg_e               seg
);

    int unsigned lim;
    always_comb lim = ((phase_len == '0) ? 1 : int'(phase_len)) * UNIT;

    // R1: the half-period count never reaches the length set by phase_len
    assert_half_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chain_en |-> (int'(half_cnt) < int'(lim)));

    // R2: data is held for as long as the serial clock stays high
    assert_dat_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> (!sclk || $stable(dat_raw)));

    // R3: segments only move forward within a frame
    assert_seg_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_adv && seg != SEG_LATCH) |=> (seg >= $past(seg)));

    // R5: the latch slot carries inactive data
    assert_latch_data_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slatch |-> !dat_raw);

    // R7: a disabled chain keeps clock and latch low
    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en |=> (!sclk && !slatch));

endmodule

bind led_chain_ctrl led_chain_chk #(.PHASE_W(PHASE_W), .UNIT(UNIT), .HC_W(HC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chain_en  (chain_en),
    .phase_len (phase_len),
    .sclk      (sclk),
    .slatch    (slatch),
    .dat_raw   (u_seq.dat_q),
    .slot_adv  (u_clk.slot_adv),
    .half_cnt  (u_clk.half_cnt),
    .seg       (u_seq.seg_q)
);

// File: tb/test_led_chain_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected bit stream and the
// monitor compares it with sdat/slatch at each sclk rising edge.
module test_led_chain_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chain_en, dat_invert, dbg_en, ud_wr, ud_sel;
    logic [6:0]  phase_len;
    logic [5:0]  hdr_len, trl_len;
    logic [7:0]  port_mask;
    logic [47:0] port_status;
    logic [16:0] dbg_word;
    logic [1:0]  ud_op;
    logic [31:0] ud_wdata;
    logic        sclk, sdat, slatch;

    always #2.5 clk = ~clk;

    led_chain_ctrl i_led_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .dat_invert(dat_invert),
        .phase_len(phase_len), .hdr_len(hdr_len), .trl_len(trl_len),
        .port_mask(port_mask), .port_status(port_status), .dbg_en(dbg_en),
        .dbg_word(dbg_word), .ud_wr(ud_wr), .ud_sel(ud_sel), .ud_op(ud_op),
        .ud_wdata(ud_wdata), .sclk(sclk), .sdat(sdat), .slatch(slatch)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    int          half_len = 64;
    logic [31:0] hdr_m = '0;
    logic [31:0] trl_m = '0;
    logic [1:0]  expq[$];
    string       reqq[$];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_item(bit lat, bit d, string req);
        expq.push_back({lat, d});
        reqq.push_back(req);
    endtask

    // Queue one frame from the current settings and the bench data model.
    task automatic push_frame(string req);
        int hl = (hdr_len > 32) ? 32 : int'(hdr_len);
        int tl = (trl_len > 32) ? 32 : int'(trl_len);
        for (int i = 0; i < hl; i++) push_item(1'b0, hdr_m[i], req);
        for (int p = 0; p < 8; p++)
            if (port_mask[p])
                for (int b = 0; b < 6; b++) push_item(1'b0, port_status[p*6+b], req);
        if (dbg_en)
            for (int b = 0; b < 17; b++) push_item(1'b0, dbg_word[b], req);
        for (int i = 0; i < tl; i++) push_item(1'b0, trl_m[i], req);
        push_item(1'b1, 1'b0, "R5");
    endtask

    task automatic ud_write(bit sel, logic [1:0] op, logic [31:0] d);
        @(negedge clk);
        ud_wr = 1'b1; ud_sel = sel; ud_op = op; ud_wdata = d;
        @(negedge clk);
        ud_wr = 1'b0;
        case (op)
            2'd0: if (sel) trl_m = d; else hdr_m = d;
            2'd1: if (sel) trl_m = trl_m | d; else hdr_m = hdr_m | d;
            2'd2: if (sel) trl_m = trl_m & ~d; else hdr_m = hdr_m & ~d;
            default: ;
        endcase
    endtask

    // Queue n frames, enable, wait until every item is compared, disable.
    task automatic run_frames(int n, string req);
        half_len = ((phase_len == 0) ? 1 : int'(phase_len)) * 64;
        for (int k = 0; k < n; k++) push_frame(req);
        @(negedge clk);
        chain_en = 1'b1;
        while (expq.size() != 0) @(posedge clk);
        @(negedge clk);
        chain_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic idle_check(string tag);
        repeat (20) @(negedge clk);
        check(sclk == 1'b0, "R7", {tag, " sclk idle"}, sclk, 0);
        check(slatch == 1'b0, "R7", {tag, " slatch idle"}, slatch, 0);
        check(sdat == dat_invert, "R7", {tag, " sdat idle"}, sdat, dat_invert);
    endtask

    // Monitor: timing of sclk edges, data stability, scoreboard compare.
    int   cyc = 0, en_cyc = 0, last_rise = 0;
    bit   have_rise = 0, hi_glitch = 0;
    logic prev_sclk = 0, prev_sdat = 0, prev_en = 0;
    always @(posedge clk) begin
        #1;
        cyc++;
        if (!chain_en) have_rise = 0;
        else if (!prev_en) en_cyc = cyc;
        if (chain_en && sclk && !prev_sclk) begin
            if (have_rise)
                check(cyc - last_rise == 2 * half_len, "R1", "sclk period",
                      cyc - last_rise, 2 * half_len);
            else
                check(cyc - en_cyc == half_len, "R1", "first sclk rise",
                      cyc - en_cyc, half_len);
            have_rise = 1;
            last_rise = cyc;
            hi_glitch = 0;
            if (expq.size() != 0) begin
                logic [1:0] it;
                string      r;
                it = expq.pop_front();
                r  = reqq.pop_front();
                check(sdat == (it[0] ^ dat_invert), r, "sdat bit", sdat, it[0] ^ dat_invert);
                check(slatch == it[1], r, "slatch", slatch, it[1]);
            end
        end else if (sclk && prev_sclk && sdat != prev_sdat) begin
            hi_glitch = 1;
        end
        if (chain_en && !sclk && prev_sclk)
            check(!hi_glitch, "R2", "sdat stable while sclk high", hi_glitch, 0);
        prev_sclk = sclk;
        prev_sdat = sdat;
        prev_en   = chain_en;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; chain_en = 0; dat_invert = 0; dbg_en = 0; ud_wr = 0; ud_sel = 0;
        phase_len = 7'd1; hdr_len = 0; trl_len = 0; port_mask = 0;
        port_status = 48'h0; dbg_word = 0; ud_op = 0; ud_wdata = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        idle_check("after reset");

        // R8: reset value of the header word is zero
        hdr_len = 6'd4;
        run_frames(1, "R8");

        // R3: header only, two back-to-back frames
        ud_write(1'b0, 2'd0, 32'h0000_0015);
        hdr_len = 6'd5;
        run_frames(2, "R3");

        // R8: set, clear and keep operations on the header word
        ud_write(1'b0, 2'd1, 32'h0000_00A0);
        ud_write(1'b0, 2'd2, 32'h0000_0001);
        ud_write(1'b0, 2'd3, 32'hFFFF_FFFF);
        hdr_len = 6'd8;
        run_frames(1, "R8");

        // R3/R4: port fields only, ascending port order, empty header
        hdr_len = 0;
        port_mask = 8'b1000_0101;
        port_status = 48'hA5C3_0F96_3C5A;
        run_frames(1, "R3");

        // R4/R6: trailer length clamped, debug word, inverted data, phase 2
        ud_write(1'b1, 2'd0, 32'hDEAD_BEEF);
        port_mask = 0; hdr_len = 6'd3; trl_len = 6'd40;
        dbg_en = 1; dbg_word = 17'h1_2B4D; dat_invert = 1; phase_len = 7'd2;
        idle_check("inverted");
        run_frames(1, "R6");
        dat_invert = 0; phase_len = 7'd1;

        // R4/R5: every segment empty leaves latch-only frames
        hdr_len = 0; trl_len = 0; dbg_en = 0;
        run_frames(3, "R4");

        // R1: phase of zero acts as one unit
        phase_len = 7'd0;
        run_frames(2, "R1");
        phase_len = 7'd1;

        // R9: header length change mid-frame applies to the next frame
        ud_write(1'b0, 2'd0, 32'h0000_000B);
        hdr_len = 6'd2;
        push_frame("R9");
        hdr_len = 6'd4;
        push_frame("R9");
        hdr_len = 6'd2;
        half_len = 64;
        @(negedge clk);
        chain_en = 1'b1;
        repeat (10) @(negedge clk);
        hdr_len = 6'd4;
        while (expq.size() != 0) @(posedge clk);
        @(negedge clk);
        chain_en = 1'b0;
        idle_check("after R9 run");

        // R3: full frame with every segment at its maximum
        hdr_len = 6'd32; trl_len = 6'd32; port_mask = 8'hFF; dbg_en = 1;
        port_status = 48'h9E37_79B9_7F4A;
        run_frames(1, "R3");
        idle_check("final");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule